// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a processor's load/store stage and a 32-bit little-endian data memory. For every request it adds a base register to a sign-extended 12-bit offset to form the byte address, and it decides which byte lanes of the memory word take part. For a store it builds the byte-enable strobes and copies the source data into every lane it could land in. For a load it keeps the access size, signedness and lane from the request cycle. When the memory word comes back one cycle later, it picks out the addressed byte or halfword and widens it to 32 bits.

The request side is a valid/ready stream. The request is accepted in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` follows the memory's `mem_ready`. A request that is not accepted must be held by the core. A misaligned request is never passed to memory. `misaligned` is raised while it is presented, and the core is expected to withdraw it. The response side has no back-pressure: memory returns `mem_rsp_valid` with the data exactly one cycle after it accepts a load, and `ld_valid` and `ld_data` appear in that same cycle.

Access size and signedness come from a 3-bit code. Bit 2 selects zero extension for loads. Bits [1:0] select the size: 00 is byte, 01 is halfword, and 10 or 11 is word.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32.
- R2: A byte store drives `mem_strb` = 4'b0001 shifted left by address bits [1:0], and drives `mem_wdata` as the low byte of `req_wdata` copied into all four lanes.
- R3: A halfword store drives `mem_strb` = 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1, and drives `mem_wdata` as the low halfword copied into both halves.
- R4: A word store drives `mem_strb` = 4'b1111 and passes `req_wdata` through unchanged.
- R5: A halfword access with address bit 0 set, or a word access with address bits [1:0] nonzero, raises `misaligned` while `req_valid` is high. In that case `mem_valid` is 0 and `mem_strb` is 0. Byte accesses are never misaligned.
- R6: A load drives `mem_we` = 0 and `mem_strb` = 0. A store drives `mem_we` = 1.
- R7: `mem_valid` is `req_valid` with no misalignment, and `req_ready` equals `mem_ready`.
- R8: A signed byte load (code 000) returns the byte at lane address[1:0] of `mem_rdata`, with bit 7 copied into bits [31:8].
- R9: An unsigned byte load (code 100) returns that byte with bits [31:8] zero.
- R10: A halfword load returns `mem_rdata[15:0]` when address bit 1 is 0 and `mem_rdata[31:16]` when it is 1. Bits [31:16] are filled with copies of bit 15 for code 001, or with zeros for code 101.
- R11: A word load returns `mem_rdata` unchanged.
- R12: The load result uses the size, signedness and lane captured when the load was accepted. Request inputs in the response cycle have no effect on `ld_data`, and `ld_valid` follows `mem_rsp_valid`.
- R13: After reset, with no request and no response, `mem_valid`, `ld_valid` and `misaligned` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_is_store | input | 1 | 1 for store, 0 for load |
| req_funct3 | input | 3 | Size and signedness code |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed offset |
| req_wdata | input | 32 | Store source register |
| misaligned | output | 1 | Current request is misaligned |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address |
| mem_we | output | 1 | Write enable |
| mem_strb | output | 4 | Byte-lane write strobes |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rdata | input | 32 | Returned memory word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Address, strobe, store data, misalignment and handshake outputs are combinational from the request, so they are due in the cycle the request is driven. The bench checks them shortly after driving inputs on the falling edge. A load result is due exactly one cycle after acceptance. The bench supplies the response on the next falling edge and checks `ld_data` shortly after. In that same cycle it also replaces the request inputs with unrelated random values, so that a result taken from the live request instead of the captured one is caught.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  function automatic acc_size_e size_of(input logic [2:0] f3);
    case (f3[1:0])
      2'b00:   return SZ_BYTE;
      2'b01:   return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign addr    = base + off_ext;
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  acc_size_e            size,
  input  logic                 is_store,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [DATA_W-1:0]    src,
  output logic                 mis,
  output logic [LANES-1:0]     strb,
  output logic [DATA_W-1:0]    wdata
);
  localparam int HALVES = LANES / 2;

  always_comb begin
    case (size)
      SZ_BYTE: mis = 1'b0;
      SZ_HALF: mis = lane[0];
      default: mis = |lane;
    endcase
  end

  always_comb begin
    logic [LANES-1:0] raw;
    case (size)
      SZ_BYTE: raw = {{(LANES-1){1'b0}}, 1'b1} << lane;
      SZ_HALF: raw = {{(LANES-2){1'b0}}, 2'b11} << {lane[LANE_BITS-1:1], 1'b0};
      default: raw = '1;
    endcase
    strb = (is_store && !mis) ? raw : '0;
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
        case (size)
          SZ_BYTE: wdata[8*g +: 8] = src[7:0];
          SZ_HALF: wdata[8*g +: 8] = src[8*(g%2) +: 8];
          default: wdata[8*g +: 8] = src[8*g +: 8];
        endcase
      end
    end
  endgenerate

  logic unused_h;
  assign unused_h = (HALVES == 0);
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  acc_size_e            size,
  input  logic                 zext,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    result
);
  logic [DATA_W-1:0] shifted;
  logic [7:0]        b;
  logic [15:0]       h;

  assign shifted = rdata >> {lane[LANE_BITS-1:1], 1'b0, 3'b000} >> {lane[0], 3'b000};
  assign b = shifted[7:0];
  assign h = rdata[{lane[LANE_BITS-1:1], 4'b0000} +: 16];

  always_comb begin
    case (size)
      SZ_BYTE: result = {{(DATA_W-8){b[7] & ~zext}}, b};
      SZ_HALF: result = {{(DATA_W-16){h[15] & ~zext}}, h};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_is_store,
  input  logic [2:0]  req_funct3,
  input  logic [31:0] req_base,
  input  logic [11:0] req_offset,
  input  logic [31:0] req_wdata,
  output logic        misaligned,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  output logic        mem_we,
  output logic [3:0]  mem_strb,
  output logic [31:0] mem_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rdata,
  output logic        ld_valid,
  output logic [31:0] ld_data
);
  acc_size_e            req_size;
  logic                 mis_raw;
  logic                 ld_accept;
  acc_size_e            ld_size_q;
  logic                 ld_zext_q;
  logic [LANE_BITS-1:0] ld_lane_q;

  assign req_size = size_of(req_funct3);

  lsu_agen #(.ADDR_W(DATA_W), .OFF_W(12)) u_agen (
    .base(req_base), .offset(req_offset), .addr(mem_addr)
  );

  lsu_store_lane u_st (
    .size(req_size), .is_store(req_is_store),
    .lane(mem_addr[LANE_BITS-1:0]), .src(req_wdata),
    .mis(mis_raw), .strb(mem_strb), .wdata(mem_wdata)
  );

  assign misaligned = req_valid & mis_raw;
  assign mem_valid  = req_valid & ~mis_raw;
  assign mem_we     = req_is_store;
  assign req_ready  = mem_ready;
  assign ld_accept  = mem_valid & mem_ready & ~req_is_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_size_q <= SZ_BYTE;
      ld_zext_q <= 1'b0;
      ld_lane_q <= '0;
    end else if (ld_accept) begin
      ld_size_q <= req_size;
      ld_zext_q <= req_funct3[2];
      ld_lane_q <= mem_addr[LANE_BITS-1:0];
    end
  end

  lsu_load_extract u_ld (
    .size(ld_size_q), .zext(ld_zext_q), .lane(ld_lane_q),
    .rdata(mem_rdata), .result(ld_data)
  );

  assign ld_valid = mem_rsp_valid;
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_is_store,
  input logic [2:0]  req_funct3,
  input logic        misaligned,
  input logic        mem_valid,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_strb,
  input logic [31:0] mem_wdata,
  input logic        mem_rsp_valid,
  input logic [31:0] ld_data
);
  assert_mis_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (!mem_valid && mem_strb == 4'b0000));

  assert_byte_strb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_is_store && req_funct3[1:0] == 2'b00)
      |-> ($countones(mem_strb) == 1 && mem_strb[mem_addr[1:0]]
           && mem_wdata[31:24] == mem_wdata[7:0]));

  assert_word_strb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_is_store && req_funct3[1] == 1'b1) |-> mem_strb == 4'b1111);

  assert_load_no_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_store) |-> mem_strb == 4'b0000);

  assert_ubyte_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && $past(mem_valid && req_ready && !req_is_store && req_funct3 == 3'b100))
      |-> ld_data[31:8] == 24'h0);
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_is_store(req_is_store), .req_funct3(req_funct3), .misaligned(misaligned),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_strb(mem_strb),
  .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .ld_data(ld_data)
);

// File: tb/tb_lsu_lane_align.sv
module tb_lsu_lane_align;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_is_store = 0, mem_ready = 0, mem_rsp_valid = 0;
  logic [2:0] req_funct3 = 0;
  logic [31:0] req_base = 0, req_wdata = 0, mem_rdata = 0;
  logic [11:0] req_offset = 0;
  logic req_ready, misaligned, mem_valid, mem_we, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0] mem_strb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_align dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_addr(input logic [31:0] b, input logic [11:0] o);
    return b + {{20{o[11]}}, o};
  endfunction
  function automatic bit e_mis(input logic [2:0] f, input logic [1:0] a);
    if (f[1:0] == 2'b00) return 0;
    if (f[1:0] == 2'b01) return a[0];
    return a != 2'b00;
  endfunction
  function automatic logic [3:0] e_strb(input logic [2:0] f, input logic [1:0] a);
    if (f[1:0] == 2'b00) return 4'b0001 << a;
    if (f[1:0] == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction
  function automatic logic [31:0] e_wd(input logic [2:0] f, input logic [31:0] d);
    if (f[1:0] == 2'b00) return {4{d[7:0]}};
    if (f[1:0] == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction
  function automatic logic [31:0] e_ld(input logic [2:0] f, input logic [1:0] a, input logic [31:0] r);
    logic [7:0] b; logic [15:0] h;
    b = r[8*a +: 8];
    h = a[1] ? r[31:16] : r[15:0];
    if (f[1:0] == 2'b00) return f[2] ? {24'h0, b} : {{24{b[7]}}, b};
    if (f[1:0] == 2'b01) return f[2] ? {16'h0, h} : {{16{h[15]}}, h};
    return r;
  endfunction

  task automatic txn(input bit st, input logic [2:0] f, input logic [31:0] b,
                     input logic [11:0] o, input logic [31:0] wd, input bit rdy,
                     input logic [31:0] rd);
    logic [31:0] a; bit m;
    @(negedge clk);
    mem_rsp_valid = 0;
    req_valid = 1; req_is_store = st; req_funct3 = f; req_base = b;
    req_offset = o; req_wdata = wd; mem_ready = rdy;
    #1;
    a = e_addr(b, o); m = e_mis(f, a[1:0]);
    chk("R1 addr", mem_addr, a);
    chk("R5 misaligned", {31'h0, misaligned}, {31'h0, m});
    chk("R7 mem_valid", {31'h0, mem_valid}, {31'h0, !m});
    chk("R7 req_ready", {31'h0, req_ready}, {31'h0, rdy});
    chk("R6 mem_we", {31'h0, mem_we}, {31'h0, st});
    if (!st || m) chk("R5/R6 strb off", {28'h0, mem_strb}, 32'h0);
    else begin
      chk(f[1:0]==0 ? "R2 strb" : f[1:0]==1 ? "R3 strb" : "R4 strb",
          {28'h0, mem_strb}, {28'h0, e_strb(f, a[1:0])});
      chk(f[1:0]==0 ? "R2 wdata" : f[1:0]==1 ? "R3 wdata" : "R4 wdata",
          mem_wdata, e_wd(f, wd));
    end
    if (!st && !m && rdy) begin
      @(negedge clk);
      req_valid = 0; req_is_store = $urandom; req_funct3 = $urandom;
      req_base = $urandom; req_offset = $urandom;
      mem_rsp_valid = 1; mem_rdata = rd;
      #1;
      chk("R12 ld_valid", {31'h0, ld_valid}, 32'h1);
      chk(f[1:0]==0 ? (f[2] ? "R9 ld" : "R8 ld") : f[1:0]==1 ? "R10 ld" : "R11 ld",
          ld_data, e_ld(f, a[1:0], rd));
    end
    @(negedge clk);
    req_valid = 0; mem_rsp_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD*40000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*3);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R13 mem_valid", {31'h0, mem_valid}, 32'h0);
    chk("R13 ld_valid", {31'h0, ld_valid}, 32'h0);
    chk("R13 misaligned", {31'h0, misaligned}, 32'h0);
    // directed corners
    txn(1, 3'b000, 32'h1000, 12'h003, 32'hAABBCCDD, 1, 0);          // R2 lane 3
    txn(1, 3'b001, 32'h1000, 12'h002, 32'h1234BEEF, 1, 0);          // R3 upper half
    txn(1, 3'b010, 32'h1000, 12'h000, 32'hCAFEF00D, 1, 0);          // R4
    txn(1, 3'b010, 32'h1000, 12'h002, 32'hCAFEF00D, 1, 0);          // R5 word
    txn(1, 3'b001, 32'h1000, 12'h001, 32'hCAFEF00D, 1, 0);          // R5 half
    txn(0, 3'b000, 32'h1000, 12'hFFF, 0, 1, 32'h80FF7F01);          // R1 negative, R8
    txn(0, 3'b100, 32'h1000, 12'h003, 0, 1, 32'h80FF7F01);          // R9
    txn(0, 3'b001, 32'h1000, 12'h002, 0, 1, 32'h80FF7F01);          // R10 signed
    txn(0, 3'b101, 32'h1000, 12'h002, 0, 1, 32'h80FF7F01);          // R10 unsigned
    txn(0, 3'b010, 32'hFFFFFFFC, 12'h004, 0, 1, 32'h89ABCDEF);      // R1 wrap, R11
    txn(0, 3'b010, 32'h1000, 12'h000, 0, 0, 32'h0);                 // R7 not ready
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] f;
      f = $urandom;
      txn($urandom_range(0, 1), f, $urandom, 12'($urandom), $urandom,
          $urandom_range(0, 3) != 0, $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule